// File: doc/BRIEF.md
# Bus Break Condition Comparator

This block watches the bus cycles of one break channel and raises a break request when a cycle meets every condition that software has programmed. The conditions cover four things: which master drives the cycle (CPU or DMA controller), whether it is an instruction fetch or a data access, whether it reads or writes, and the operand size. When a size is set, the bus data is also compared with a stored break value. That comparison can be masked bit by bit. For byte accesses, the byte lane that is compared depends on whether the address is even or odd.

Software programs three registers through a plain register port, and writes take effect at the next clock edge. Bus cycles arrive on a monitor stream that uses valid/ready. The block never applies back-pressure: ready is high whenever reset is low, so a beat is taken in every cycle in which valid is high. Each beat is judged against the register values that were in place when the beat arrived. A matching beat produces a break pulse of one cycle on the following clock.

Top module: `bus_break_cmp`

## Requirements
- R1: There are three registers, selected by `reg_addr`: 0 is the break value (32 bits), 1 is the data mask (32 bits) and 2 is the cycle condition. A write lands on the next clock edge. `reg_rdata` shows the selected register combinationally. Reset clears all three registers to zero.
- R2: The cycle condition register reads back as 16 bits. Its bits 15 to 8, and every bit above them, always read as zero, and writes to those bits are dropped.
- R3: The master field is condition bits 7:6. Code 00 blocks every break request, whatever the other fields hold. Codes 01 and 11 accept only CPU beats (`mon_dma`=0). Code 10 accepts only DMA beats (`mon_dma`=1).
- R4: The access-kind field is condition bits 5:4. Code 00 does not check the access kind. Code 01 requires a fetch (`mon_fetch`=1). Code 10 requires a data access (`mon_fetch`=0). Code 11 accepts either.
- R5: The direction field is condition bits 3:2. Code 00 does not check the direction. Code 01 requires a read (`mon_write`=0). Code 10 requires a write (`mon_write`=1). Code 11 accepts either.
- R6: The size field is condition bits 1:0. Code 00 checks neither the size nor the data. Codes 01 (byte), 10 (word) and 11 (longword) require `mon_size` to carry the same code, and they turn on the data comparison.
- R7: A data mask bit of 1 removes the matching data bit from the comparison. A mask bit of 0 keeps it in.
- R8: For byte size, only data bits 15:8 are compared when `mon_addr0`=0, and only bits 7:0 when `mon_addr0`=1. All other data bits are ignored.
- R9: For word size, data bits 15:0 are compared. For longword size, all 32 bits are compared.
- R10: `brk_req` is high for exactly the one cycle after an accepted beat that matches. It is low after any cycle with no accepted matching beat.
- R11: `mon_ready` is high in every cycle in which reset is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| mon_valid | input | 1 | A bus beat is present |
| mon_ready | output | 1 | The block takes the beat; high outside reset |
| mon_addr0 | input | 1 | Lowest address bit of the beat |
| mon_data | input | 32 | Data of the beat |
| mon_dma | input | 1 | 1 when the DMA controller is the master, 0 for the CPU |
| mon_fetch | input | 1 | 1 for an instruction fetch, 0 for a data access |
| mon_write | input | 1 | 1 for a write, 0 for a read |
| mon_size | input | 2 | Operand size: 01 byte, 10 word, 11 longword |
| brk_req | output | 1 | Break request pulse |

## Verification
A register write and a monitor beat can fall in the same cycle. The beat must then be judged against the register values from before the write, and the new values apply only to later beats. The random phase issues a write and a beat together in a share of its cycles. The bench computes the expected pulse from its shadow registers before it updates them, and it compares `brk_req` on the next falling edge. The byte-lane choice and the mask are exercised together, because the random beats flip a few data bits and carry random address parity.

// File: rtl/bbc_pkg.sv
package bbc_pkg;

  // Decoded live bits of the cycle condition register (bits 7:0)
  typedef struct packed {
    logic [1:0] mst;   // master select
    logic [1:0] kind;  // fetch / data access
    logic [1:0] dir;   // read / write
    logic [1:0] size;  // operand size, enables data compare
  } cond_t;

  typedef enum logic [1:0] {
    SZ_NONE = 2'b00,
    SZ_BYTE = 2'b01,
    SZ_WORD = 2'b10,
    SZ_LONG = 2'b11
  } size_e;

  localparam logic [1:0] SEL_VALUE = 2'd0;
  localparam logic [1:0] SEL_MASK  = 2'd1;
  localparam logic [1:0] SEL_COND  = 2'd2;

  localparam int COND_LIVE_W = 8;

  // Two-way select field: 00 skip, 01 first choice, 10 second, 11 either
  function automatic logic pick_ok(input logic [1:0] code,
                                   input logic first_hit);
    case (code)
      2'b01:   return first_hit;
      2'b10:   return !first_hit;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/bbc_regs.sv
module bbc_regs
  import bbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int COND_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [DATA_W-1:0] value_q,
  output logic [DATA_W-1:0] mask_q,
  output cond_t             cond_q
);

  localparam int PAD_W = DATA_W - COND_LIVE_W;

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= '0;
      mask_q  <= '0;
      cond_q  <= '0;
    end else if (wr) begin
      case (addr)
        SEL_VALUE: value_q <= wdata;
        SEL_MASK:  mask_q  <= wdata;
        SEL_COND:  cond_q  <= cond_t'(wdata[COND_LIVE_W-1:0]);
        default:   ;
      endcase
    end
  end

  // Reserved condition bits and the unused slot read as zero
  always_comb begin
    case (addr)
      SEL_VALUE: rdata = value_q;
      SEL_MASK:  rdata = mask_q;
      SEL_COND:  rdata = {{PAD_W{1'b0}}, cond_q};
      default:   rdata = '0;
    endcase
  end

  if (COND_W < COND_LIVE_W || COND_W > DATA_W) begin : g_bad_cond_w
    initial $error("bbc_regs: COND_W out of range");
  end

endmodule

// File: rtl/bbc_lane_sel.sv
module bbc_lane_sel
  import bbc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size,
  input  logic              addr_odd,
  output logic [DATA_W-1:0] lane_en
);

  localparam int LANES = DATA_W / 8;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic on;
    always_comb begin
      case (size_e'(size))
        SZ_LONG: on = (b < 4);
        SZ_WORD: on = (b < 2);
        SZ_BYTE: on = (b == 1 && !addr_odd) || (b == 0 && addr_odd);
        default: on = 1'b0;
      endcase
    end
    assign lane_en[b*8 +: 8] = {8{on}};
  end

endmodule

// File: rtl/bbc_attr_match.sv
module bbc_attr_match
  import bbc_pkg::*;
(
  input  cond_t      cond,
  input  logic       is_dma,
  input  logic       is_fetch,
  input  logic       is_write,
  input  logic [1:0] beat_size,
  output logic       armed,
  output logic       attr_ok
);

  logic mst_ok, kind_ok, dir_ok, size_ok;

  always_comb begin
    case (cond.mst)
      2'b00:   mst_ok = 1'b0;
      2'b10:   mst_ok = is_dma;
      default: mst_ok = !is_dma;
    endcase
    kind_ok = pick_ok(cond.kind, is_fetch);
    dir_ok  = pick_ok(cond.dir, !is_write);
    size_ok = (cond.size == SZ_NONE) || (beat_size == cond.size);
  end

  assign armed   = (cond.mst != 2'b00);
  assign attr_ok = armed && mst_ok && kind_ok && dir_ok && size_ok;

endmodule

// File: rtl/bus_break_cmp.sv
module bus_break_cmp
  import bbc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int COND_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              mon_valid,
  output logic              mon_ready,
  input  logic              mon_addr0,
  input  logic [DATA_W-1:0] mon_data,
  input  logic              mon_dma,
  input  logic              mon_fetch,
  input  logic              mon_write,
  input  logic [1:0]        mon_size,
  output logic              brk_req
);

  logic [DATA_W-1:0] value_q, mask_q, lane_en, diff;
  cond_t             cond_q;
  logic              armed, attr_ok, data_ok, hit;

  bbc_regs #(.DATA_W(DATA_W), .COND_W(COND_W)) u_regs (
    .clk    (clk),
    .rst    (rst),
    .wr     (reg_wr),
    .addr   (reg_addr),
    .wdata  (reg_wdata),
    .rdata  (reg_rdata),
    .value_q(value_q),
    .mask_q (mask_q),
    .cond_q (cond_q)
  );

  bbc_attr_match u_attr (
    .cond     (cond_q),
    .is_dma   (mon_dma),
    .is_fetch (mon_fetch),
    .is_write (mon_write),
    .beat_size(mon_size),
    .armed    (armed),
    .attr_ok  (attr_ok)
  );

  bbc_lane_sel #(.DATA_W(DATA_W)) u_lane (
    .size    (cond_q.size),
    .addr_odd(mon_addr0),
    .lane_en (lane_en)
  );

  // A mask bit of 1 drops that bit from the comparison
  assign diff      = (mon_data ^ value_q) & lane_en & ~mask_q;
  assign data_ok   = (diff == '0);
  assign mon_ready = !rst;
  assign hit       = mon_valid && mon_ready && armed && attr_ok && data_ok;

  always_ff @(posedge clk) begin
    if (rst) brk_req <= 1'b0;
    else     brk_req <= hit;
  end

endmodule

// File: rtl/bbc_chk.sv
module bbc_chk
  import bbc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              mon_valid,
  input logic              mon_ready,
  input logic              mon_dma,
  input logic              mon_fetch,
  input logic              mon_write,
  input logic [1:0]        mon_size,
  input logic              brk_req,
  input logic [DATA_W-1:0] mask_q,
  input cond_t             cond_q
);

  AST_MASK_CLEARED: assert property (@(posedge clk)
    rst |=> (mask_q == '0)); // R1

  AST_RSVD_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    (reg_addr == SEL_COND) |-> (reg_rdata[DATA_W-1:8] == '0)); // R2

  AST_OFF_NO_BREAK: assert property (@(posedge clk) disable iff (rst)
    (cond_q.mst == 2'b00) |=> !brk_req); // R3

  AST_DMA_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mon_valid && cond_q.mst == 2'b10 && !mon_dma) |=> !brk_req); // R3

  AST_FETCH_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mon_valid && cond_q.kind == 2'b01 && !mon_fetch) |=> !brk_req); // R4

  AST_WRITE_ONLY: assert property (@(posedge clk) disable iff (rst)
    (mon_valid && cond_q.dir == 2'b10 && !mon_write) |=> !brk_req); // R5

  AST_SIZE_MATCH: assert property (@(posedge clk) disable iff (rst)
    (mon_valid && cond_q.size != 2'b00 && mon_size != cond_q.size) |=> !brk_req); // R6

  AST_NO_IDLE_BREAK: assert property (@(posedge clk) disable iff (rst)
    !mon_valid |=> !brk_req); // R10

  AST_READY_HIGH: assert property (@(posedge clk) disable iff (rst)
    mon_ready); // R11

endmodule

bind bus_break_cmp bbc_chk #(.DATA_W(DATA_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_addr (reg_addr),
  .reg_rdata(reg_rdata),
  .mon_valid(mon_valid),
  .mon_ready(mon_ready),
  .mon_dma  (mon_dma),
  .mon_fetch(mon_fetch),
  .mon_write(mon_write),
  .mon_size (mon_size),
  .brk_req  (brk_req),
  .mask_q   (mask_q),
  .cond_q   (cond_q)
);

// File: tb/bus_break_cmp_tb.sv
`timescale 1ns/1ps
module bus_break_cmp_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mon_valid = 1'b0;
  logic        mon_ready;
  logic        mon_addr0 = 1'b0;
  logic [31:0] mon_data = '0;
  logic        mon_dma = 1'b0;
  logic        mon_fetch = 1'b0;
  logic        mon_write = 1'b0;
  logic [1:0]  mon_size = '0;
  logic        brk_req;

  int          n_chk = 0;
  int          n_bad = 0;
  bit          done = 0;

  logic [31:0] sh_val = '0, sh_msk = '0;
  logic [7:0]  sh_cnd = '0;
  logic        exp_q = 1'b0;
  string       exp_tag = "R10";

  always #2.5 clk = ~clk;

  bus_break_cmp u_dut (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mon_valid(mon_valid),
    .mon_ready(mon_ready), .mon_addr0(mon_addr0), .mon_data(mon_data),
    .mon_dma(mon_dma), .mon_fetch(mon_fetch), .mon_write(mon_write),
    .mon_size(mon_size), .brk_req(brk_req)
  );

  function automatic bit expect_hit(input logic [7:0] c, input logic [31:0] v,
                                    input logic [31:0] m, input logic dma,
                                    input logic fe, input logic wr,
                                    input logic [1:0] sz, input logic odd,
                                    input logic [31:0] d);
    logic [31:0] cmp;
    if (c[7:6] == 2'b00) return 0;
    if (c[7:6] == 2'b10 && !dma) return 0;
    if (c[6] && dma) return 0;
    if (c[5:4] == 2'b01 && !fe) return 0;
    if (c[5:4] == 2'b10 && fe) return 0;
    if (c[3:2] == 2'b01 && wr) return 0;
    if (c[3:2] == 2'b10 && !wr) return 0;
    if (c[1:0] != 2'b00) begin
      if (sz != c[1:0]) return 0;
      case (c[1:0])
        2'b01:   cmp = odd ? 32'h0000_00FF : 32'h0000_FF00;
        2'b10:   cmp = 32'h0000_FFFF;
        default: cmp = 32'hFFFF_FFFF;
      endcase
      if (((d ^ v) & cmp & ~m) != 0) return 0;
    end
    return 1;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Move to the next falling edge and judge the previous cycle's beat
  task automatic advance();
    @(negedge clk);
    check(exp_tag, {31'd0, brk_req}, {31'd0, exp_q});
  endtask

  // Drive one cycle: optional register write and optional beat together
  task automatic cycle(input bit do_wr, input logic [1:0] a, input logic [31:0] wd,
                       input bit do_beat, input logic dma, input logic fe,
                       input logic wr, input logic [1:0] sz, input logic odd,
                       input logic [31:0] d, input string tag);
    advance();
    reg_wr = do_wr; reg_addr = a; reg_wdata = wd;
    mon_valid = do_beat; mon_dma = dma; mon_fetch = fe; mon_write = wr;
    mon_size = sz; mon_addr0 = odd; mon_data = d;
    exp_q = do_beat && expect_hit(sh_cnd, sh_val, sh_msk, dma, fe, wr, sz, odd, d);
    exp_tag = tag;
    if (do_wr) begin
      case (a)
        2'd0: sh_val = wd;
        2'd1: sh_msk = wd;
        2'd2: sh_cnd = wd[7:0];
        default: ;
      endcase
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [31:0] wd);
    cycle(1, a, wd, 0, 0, 0, 0, 0, 0, 0, "R10");
  endtask

  task automatic beat(input logic dma, input logic fe, input logic wr,
                      input logic [1:0] sz, input logic odd,
                      input logic [31:0] d, input string tag);
    cycle(0, 0, 0, 1, dma, fe, wr, sz, odd, d, tag);
  endtask

  task automatic idle(input string tag);
    cycle(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic rd_check(input logic [1:0] a, input logic [31:0] exp, input string tag);
    idle(tag);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1979));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_check(2'd0, 32'h0, "R1");
    rd_check(2'd1, 32'h0, "R1");
    rd_check(2'd2, 32'h0, "R1");
    check("R11", {31'd0, mon_ready}, 32'd1);
    wreg(2'd0, 32'hA5C3_5A3C);
    wreg(2'd1, 32'h0F0F_0000);
    rd_check(2'd0, 32'hA5C3_5A3C, "R1");
    rd_check(2'd1, 32'h0F0F_0000, "R1");
    // R2 reserved bits
    wreg(2'd2, 32'hFFFF_FFFF);
    rd_check(2'd2, 32'h0000_00FF, "R2");
    wreg(2'd1, 32'h0);
    // R3 master select
    wreg(2'd2, 32'h0000_FF3C);
    beat(0, 1, 0, 2'b00, 0, 32'h0, "R3");
    beat(1, 0, 1, 2'b11, 0, 32'h0, "R3");
    wreg(2'd2, 32'h0000_007C);
    beat(0, 0, 1, 2'b00, 0, 32'h0, "R3");
    beat(1, 0, 1, 2'b00, 0, 32'h0, "R3");
    wreg(2'd2, 32'h0000_00FC);
    beat(0, 1, 0, 2'b00, 1, 32'h0, "R3");
    beat(1, 1, 0, 2'b00, 1, 32'h0, "R3");
    wreg(2'd2, 32'h0000_00BC);
    beat(1, 0, 0, 2'b00, 0, 32'h0, "R3");
    beat(0, 0, 0, 2'b00, 0, 32'h0, "R3");
    // R4 access kind
    wreg(2'd2, 32'h0000_0050);
    beat(0, 1, 0, 2'b00, 0, 32'h0, "R4");
    beat(0, 0, 0, 2'b00, 0, 32'h0, "R4");
    wreg(2'd2, 32'h0000_0060);
    beat(0, 1, 0, 2'b00, 0, 32'h0, "R4");
    beat(0, 0, 0, 2'b00, 0, 32'h0, "R4");
    // R5 direction
    wreg(2'd2, 32'h0000_0044);
    beat(0, 0, 0, 2'b00, 0, 32'h0, "R5");
    beat(0, 0, 1, 2'b00, 0, 32'h0, "R5");
    wreg(2'd2, 32'h0000_0048);
    beat(0, 0, 0, 2'b00, 0, 32'h0, "R5");
    beat(0, 0, 1, 2'b00, 0, 32'h0, "R5");
    // R6 size and the no-compare code
    wreg(2'd0, 32'h1111_ABCD);
    wreg(2'd2, 32'h0000_0042);
    beat(0, 0, 0, 2'b01, 0, 32'h1111_ABCD, "R6");
    beat(0, 0, 0, 2'b10, 0, 32'h1111_ABCD, "R6");
    wreg(2'd2, 32'h0000_0040);
    beat(0, 0, 0, 2'b11, 0, 32'hDEAD_BEEF, "R6");
    // R8 byte lanes by address parity
    wreg(2'd2, 32'h0000_0041);
    beat(0, 0, 0, 2'b01, 0, 32'h7777_AB00, "R8");
    beat(0, 0, 0, 2'b01, 1, 32'h7777_00CD, "R8");
    beat(0, 0, 0, 2'b01, 1, 32'h0000_CDAB, "R8");
    beat(0, 0, 0, 2'b01, 0, 32'h0000_CDAB, "R8");
    // R9 word and longword
    wreg(2'd2, 32'h0000_0042);
    beat(0, 0, 0, 2'b10, 0, 32'h9999_ABCD, "R9");
    beat(0, 0, 0, 2'b10, 0, 32'h1111_ABCC, "R9");
    wreg(2'd2, 32'h0000_0043);
    beat(0, 0, 0, 2'b11, 0, 32'h1011_ABCD, "R9");
    beat(0, 0, 0, 2'b11, 0, 32'h1111_ABCD, "R9");
    // R7 mask polarity
    beat(0, 0, 0, 2'b11, 0, 32'h1111_ABC5, "R7");
    wreg(2'd1, 32'h0000_0008);
    beat(0, 0, 0, 2'b11, 0, 32'h1111_ABC5, "R7");
    beat(0, 0, 0, 2'b11, 0, 32'h1111_ABC4, "R7");
    // R10 single pulse, then idle
    beat(0, 0, 0, 2'b11, 0, 32'h1111_ABCD, "R10");
    idle("R10");
    idle("R10");
    // Random phase, writes and beats sometimes in the same cycle
    for (int i = 0; i < 4000; i++) begin
      bit do_wr, do_bt;
      logic [1:0] a;
      logic [31:0] wd, d;
      do_wr = ($urandom_range(0, 9) == 0);
      do_bt = ($urandom_range(0, 4) != 0);
      a = 2'($urandom_range(0, 2));
      wd = $urandom();
      if (a == 2'd1) wd = wd & $urandom() & $urandom();
      if (a == 2'd2 && wd[7:6] == 2'b00) wd[6] = 1'b1;
      d = sh_val;
      if ($urandom_range(0, 2) == 0) d = d ^ (32'd1 << $urandom_range(0, 31));
      cycle(do_wr, a, wd, do_bt, 1'($urandom()), 1'($urandom()), 1'($urandom()),
            2'($urandom()), 1'($urandom()), d, "R10");
    end
    idle("R10");
    advance();
    check("R11", {31'd0, mon_ready}, 32'd1);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule